// File: doc/BRIEF.md
# Synchronized dual-ratio clock divider

This block derives two slow clocks from one fast input clock. Bank A runs at one half or one quarter of the input rate. Bank B runs at one quarter or one sixth of the input rate. Each bank has its own ratio select. Both banks are decoded from a single shared modulo-12 count, so any rising edge the two banks have in common falls on the same input edge. Both outputs are registered on the rising input edge.

A run enable is captured on the falling input edge. Its effect therefore reaches the shared count on the next rising edge, and only while the gated internal clock is low. When the enable is off, the count stops and both outputs keep their current level. No pulse is ever cut short. A ratio select takes effect only at the 12-count boundary, where every decoded output is low. A change of ratio therefore never leaves a partial period. A synchronous active-low reset puts both banks into one common aligned phase. Without a reset, the shared count keeps the two banks aligned from whatever state they start in.

Top module: `clk_div_dual`

## Requirements
- R1: A rising edge with `rst_n` low drives `clk_a` and `clk_b` low on that edge. It places the shared count at its last phase (11), so the first enabled edge after reset starts phase 0.
- R2: Bank A with `sel_a`=0 divides by 2 (high on even phases). With `sel_a`=1 it divides by 4 (high for 2 enabled edges, low for 2).
- R3: Bank B with `sel_b`=0 divides by 4 (2 high, 2 low). With `sel_b`=1 it divides by 6 (3 high, 3 low).
- R4: On every enabled edge that takes the shared count from 11 to 0, `clk_a` and `clk_b` both rise together on that same input edge.
- R5: `en` is sampled on the falling edge of `clk`. A value captured at a falling edge governs the following rising edge.
- R6: While the captured enable is low, the shared count and both outputs hold. When it returns high, counting resumes from the held phase.
- R7: A select value is taken only at the 11-to-0 boundary, and also during reset. Select changes at other times have no effect until the next boundary.
- R8: No high pulse on either output is shorter than half the period of the ratio in force when that pulse began. For example, bank B highs last at least 2 input cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable, sampled on the falling clock edge |
| sel_a | input | 1 | Bank A ratio: 0 selects divide by 2, 1 selects divide by 4 |
| sel_b | input | 1 | Bank B ratio: 0 selects divide by 4, 1 selects divide by 6 |
| clk_a | output | 1 | Bank A divided clock |
| clk_b | output | 1 | Bank B divided clock |

## Verification
A change on `en` made before a falling edge reaches the outputs on the next rising edge, which is half an input cycle later. A select change first shows on the edge that starts the next 12-phase frame. A reset shows on the rising edge where it is sampled. The bench drives inputs 2 ns after a rising edge, so each falling edge samples settled values. The reference model updates at every rising edge and compares 1 ns later, after the output registers have changed. Pulse widths are tracked on the outputs, measured against the ratio the model had in force when each pulse rose.

// File: rtl/clk_div_pkg.sv
// Shared constants for the dual-ratio divider.
// Assumes every selectable ratio is even and divides the frame length.
package clk_div_pkg;
    localparam int unsigned FRAME_LEN = 12;
    localparam int unsigned FRAME_W   = $clog2(FRAME_LEN);
endpackage

// File: rtl/clk_div_en_capture.sv
// Captures the run enable on the falling clock edge.
// Assumes rst_n is stable around the falling edge; reset forces the run state off.
module clk_div_en_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic run_q
);
    // Falling-edge enable flop: gating changes only while the internal clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= en;
    end
endmodule

// File: rtl/clk_div_phase_ctr.sv
// Shared modulo-FRAME_LEN phase counter that every bank decodes.
// Assumes FRAME_LEN >= 2. Reset parks the count on the last phase.
module clk_div_phase_ctr #(
    parameter int unsigned FRAME_LEN = 12,
    parameter int unsigned FRAME_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_q,
    output logic [FRAME_W-1:0] ph_q,
    output logic [FRAME_W-1:0] ph_nxt,
    output logic               wrap_adv
);
    localparam logic [FRAME_W-1:0] LAST = FRAME_W'(FRAME_LEN - 1);

    // Next phase: advance and wrap when running, otherwise hold.
    always_comb begin
        wrap_adv = run_q && (ph_q == LAST);
        if (!run_q)       ph_nxt = ph_q;
        else if (wrap_adv) ph_nxt = '0;
        else              ph_nxt = ph_q + 1'b1;
    end

    // Phase register with synchronous reset to the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= LAST;
        else        ph_q <= ph_nxt;
    end

    // R6
    frozen_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> $stable(ph_q));

    // R1
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q <= LAST);
endmodule

// File: rtl/clk_div_bank.sv
// One output bank: registers a ratio select at frame boundaries and decodes
// a 50% duty clock from the shared phase. Assumes both ratios are even.
module clk_div_bank #(
    parameter int unsigned RATIO_LO = 2,
    parameter int unsigned RATIO_HI = 4,
    parameter int unsigned FRAME_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_q,
    input  logic               sel,
    input  logic [FRAME_W-1:0] ph_nxt,
    input  logic               wrap_adv,
    output logic               out_q
);
    logic        sel_q;
    logic        sel_nxt;
    int unsigned ratio;
    logic        dec;

    // Select in force for the phase being entered; new value only at a boundary.
    always_comb begin
        sel_nxt = wrap_adv ? sel : sel_q;
        ratio   = sel_nxt ? RATIO_HI : RATIO_LO;
        dec     = ((int'(ph_nxt) % ratio) < (ratio / 2));
    end

    // Select register: loaded during reset and at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= sel;
        else        sel_q <= sel_nxt;
    end

    // Output register: low in reset, holds while stopped, else decoded phase.
    always_ff @(posedge clk) begin
        if (!rst_n)     out_q <= 1'b0;
        else if (run_q) out_q <= dec;
    end

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_adv |=> $stable(sel_q));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> $stable(out_q));

    generate
        if (RATIO_LO >= 4) begin : g_min_high
            // R8
            min_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(out_q) |=> out_q);
        end
    endgenerate
endmodule

// File: rtl/clk_div_dual.sv
// Top: two divided clocks decoded from one shared phase counter, with a
// falling-edge enable. Assumes ratios divide the frame length in clk_div_pkg.
module clk_div_dual #(
    parameter int unsigned A_LO = 2,
    parameter int unsigned A_HI = 4,
    parameter int unsigned B_LO = 4,
    parameter int unsigned B_HI = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sel_a,
    input  logic sel_b,
    output logic clk_a,
    output logic clk_b
);
    import clk_div_pkg::*;

    logic               run_q;
    logic [FRAME_W-1:0] ph_q;
    logic [FRAME_W-1:0] ph_nxt;
    logic               wrap_adv;

    clk_div_en_capture u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .run_q (run_q)
    );

    clk_div_phase_ctr #(.FRAME_LEN(FRAME_LEN), .FRAME_W(FRAME_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_q    (run_q),
        .ph_q     (ph_q),
        .ph_nxt   (ph_nxt),
        .wrap_adv (wrap_adv)
    );

    clk_div_bank #(.RATIO_LO(A_LO), .RATIO_HI(A_HI), .FRAME_W(FRAME_W)) u_bank_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_q    (run_q),
        .sel      (sel_a),
        .ph_nxt   (ph_nxt),
        .wrap_adv (wrap_adv),
        .out_q    (clk_a)
    );

    clk_div_bank #(.RATIO_LO(B_LO), .RATIO_HI(B_HI), .FRAME_W(FRAME_W)) u_bank_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_q    (run_q),
        .sel      (sel_b),
        .ph_nxt   (ph_nxt),
        .wrap_adv (wrap_adv),
        .out_q    (clk_b)
    );

    // R4
    frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_adv |=> (clk_a && clk_b));

    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> (!clk_a && !clk_b));
endmodule

// File: tb/tb_clk_div_dual.sv
module tb_clk_div_dual;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic sel_a = 1'b0;
    logic sel_b = 1'b0;
    logic clk_a, clk_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    bit m_en = 1'b0;
    int t = -1;
    int na = 2, nb = 4;
    bit ea = 1'b0, eb = 1'b0;
    bit model_live = 1'b0;
    // pulse tracking
    int run_a = 0, run_b = 0, ra = 2, rb = 4;
    bit pa = 1'b0, pb = 1'b0;

    always #2.5 clk = ~clk;

    clk_div_dual dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .sel_a(sel_a), .sel_b(sel_b),
        .clk_a(clk_a), .clk_b(clk_b)
    );

    task automatic chk(input string req, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
        end
    endtask

    // R5: model enable captured on the falling edge
    always @(negedge clk) m_en = rst_n ? en : 1'b0;

    // model update at rising edge, compare 1 ns later
    initial begin
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                t = -1; na = sel_a ? 4 : 2; nb = sel_b ? 6 : 4;  // R7 load in reset
                ea = 1'b0; eb = 1'b0;
                model_live = 1'b1;
            end else if (m_en) begin
                t++;
                if (t % 12 == 0) begin na = sel_a ? 4 : 2; nb = sel_b ? 6 : 4; end
                ea = (t % na) < (na / 2);
                eb = (t % nb) < (nb / 2);
            end
            #1;
            if (model_live) begin
                chk(rst_n ? "R2/R5/R6/R7 bank A" : "R1 bank A", clk_a, ea);
                chk(rst_n ? "R3/R5/R6/R7 bank B" : "R1 bank B", clk_b, eb);
                if (rst_n && m_en && t % 12 == 0 && t >= 0)
                    chk("R4 frame edge", clk_a & clk_b, 1'b1);
                // R8 pulse widths
                if (!rst_n) begin run_a = 0; run_b = 0; end
                else begin
                    if (clk_a && !pa) begin ra = na; run_a = 0; end
                    if (clk_b && !pb) begin rb = nb; run_b = 0; end
                    if (clk_a) run_a++;
                    if (clk_b) run_b++;
                    if (!clk_a && pa) begin
                        checks++;
                        if (run_a < ra / 2) begin errors++;
                            $display("FAIL R8 bank A high run actual=%0d expected>=%0d", run_a, ra/2); end
                    end
                    if (!clk_b && pb) begin
                        checks++;
                        if (run_b < rb / 2) begin errors++;
                            $display("FAIL R8 bank B high run actual=%0d expected>=%0d", run_b, rb/2); end
                    end
                end
                pa = clk_a; pb = clk_b;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1; en = 1'b1;
        step(48);                                   // R2/R3 sel 0/0
        sel_a = 1'b1; step(5); sel_b = 1'b1;        // R7 mid-frame changes
        step(48);
        sel_a = 1'b0; step(30);
        sel_b = 1'b0; sel_a = 1'b1; step(40);
        en = 1'b0; step(7); en = 1'b1; step(3);     // R6 freeze then resume
        en = 1'b0; step(1); en = 1'b1; step(13);
        sel_b = 1'b1; en = 1'b0; step(4); en = 1'b1; step(29);
        rst_n = 1'b0; step(2); rst_n = 1'b1; step(40); // R1 mid-run reset
        for (int i = 0; i < 60; i++) begin
            en = (i % 5) != 3; sel_a = i[2]; sel_b = i[3];
            step(3);
        end
        en = 1'b1; step(30);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule